// File: doc/BRIEF.md
# Daisy-Chained Central Bus Arbiter

This block arbitrates a shared bus among a chain of device cells through one central controller. Each device cell drives a single shared request line, which is the OR of all cells. The controller therefore learns only that somebody is asking, not who. Once it sees a request, the controller raises one grant wire into the first cell. Each cell either keeps that grant, if it has a request outstanding, or passes it down to the next cell. Priority comes only from position in the chain: the cell nearest the controller wins.

A cell records a request pulse from its device in a sticky pending flag. While the flag is set, the cell re-drives the shared request line once every `RETRY_PERIOD` cycles until it wins the bus. An ordinary grant lasts one bus cycle. A halt command makes the controller keep the grant raised, so that a block transfer is not broken up. The owning cell keeps the bus until a release command ends the hold. A cell claims the bus only on the rising edge of its incoming grant, so an upstream cell that starts asking during a held grant cannot take the bus.

Top module: `chain_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, `bus_req`, `grant_root`, `held` and every `dev_own` bit are low.
- R2: A pulse on `dev_ask[i]` sets the pending flag of cell i at the next clock edge, and cell i drives the shared request line in the cycle that follows. `bus_req` is the OR of all cells' drives.
- R3: If the controller is idle and sees `bus_req` high in a cycle, it raises `grant_root` in the next cycle. `grant_root` never rises without `bus_req` in the previous cycle.
- R4: When the grant rises, the lowest-numbered pending cell takes it and `dev_own` shows that cell alone. Cells without a pending flag pass the grant down the chain. Cells below the owner see no grant.
- R5: The pending flag stays set until its cell takes the bus. A `dev_ask` pulse on a cell that is already pending has no effect, so it produces no extra grant.
- R6: A pending cell drives the request line in its first pending cycle and then once every `RETRY_PERIOD` cycles. With several cells asking in the same cycle, the k-th winner (k counting from 0) owns the bus 1 + `RETRY_PERIOD`*k cycles after the first pending cycle.
- R7: Without a hold, `grant_root` stays high for exactly one cycle. The owner's pending flag clears, so the owner stops requesting.
- R8: A `halt_cmd` pulse sets a hold, and a `release_cmd` pulse clears it. If both arrive in the same cycle, release wins. While the hold is set, a raised grant stays raised. The grant drops in the cycle after the release is sampled.
- R9: At most one `dev_own` bit is high in any cycle. While `grant_root` stays high across consecutive cycles, `dev_own` does not change, even if an upstream cell becomes pending.
- R10: `held` reports the hold state one cycle after the command that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ask | input | N_DEV | One-cycle request pulse from each device |
| halt_cmd | input | 1 | Pulse: keep the current grant until release |
| release_cmd | input | 1 | Pulse: end the hold |
| bus_req | output | 1 | Shared OR of all cells' request drives |
| grant_root | output | 1 | Controller grant into cell 0 |
| dev_own | output | N_DEV | Bus ownership per cell, at most one high |
| held | output | 1 | Hold state of the controller |

## Verification
The embedded assertions check these properties on every cycle:
- single ownership and ownership frozen across a continuous grant;
- a grant rising only after a sampled request;
- one-cycle grants without a hold, and grants kept through a hold and dropped on release;
- sticky pending flags and isolated retry pulses.

The bench's scenarios are needed to show what a per-cycle property cannot:
- the chain priority order over every combination of simultaneous requesters;
- the exact cycle of each successive winner, which follows from the retry period;
- that a duplicate request pulse grants nothing extra;
- that a cell asking upstream during a held grant waits for its next retry after the release.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_GRANT = 1'b1
  } arb_state_e;

  // Next value of a modulo-period retry counter.
  function automatic int unsigned retry_step(input int unsigned cnt,
                                             input int unsigned period);
    if (cnt + 1 >= period) return 0;
    return cnt + 1;
  endfunction

  // Hold flag update: release has priority over halt.
  function automatic logic hold_next(input logic hold,
                                     input logic halt,
                                     input logic rel);
    return ~rel & (hold | halt);
  endfunction

  // First cycle a cell of a given rank may own the bus, counted from its first pending cycle.
  function automatic int unsigned win_offset(input int unsigned rank,
                                             input int unsigned period);
    return 1 + period * rank;
  endfunction

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic halt_cmd,
  input  logic release_cmd,
  output logic grant_root,
  output logic held
);

  arb_state_e state_q, state_d;
  logic       hold_q, hold_d;

  assign hold_d = hold_next(hold_q, halt_cmd, release_cmd);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:  if (bus_req) state_d = ARB_GRANT;
      ARB_GRANT: state_d = hold_d ? ARB_GRANT : ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign grant_root = (state_q == ARB_GRANT);
  assign held       = hold_q;

  AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_root) |-> $past(bus_req)); // R3
  AST_IDLE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_root && bus_req |=> grant_root); // R3
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_root && !held && !halt_cmd |=> !grant_root); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_root && held && !release_cmd |=> grant_root); // R8
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_root && release_cmd |=> !grant_root); // R8
  AST_HELD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd && !release_cmd |=> held); // R10

endmodule

// File: rtl/arb_cell.sv
module arb_cell
  import arb_pkg::*;
#(
  parameter int unsigned RETRY_PERIOD = 3,
  localparam int unsigned CW = (RETRY_PERIOD > 2) ? $clog2(RETRY_PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ask,
  input  logic gnt_in,
  output logic gnt_out,
  output logic req_out,
  output logic own
);

  logic          pend_q;
  logic          own_q;
  logic          gnt_in_q;
  logic [CW-1:0] cnt_q;
  logic          gnt_rise;
  logic          take;

  // A cell may only claim on a fresh grant edge; it cannot steal a held grant.
  assign gnt_rise = gnt_in & ~gnt_in_q;
  assign take     = gnt_rise & pend_q;
  assign own      = gnt_in & (own_q | take);
  assign gnt_out  = gnt_in & ~own;
  assign req_out  = pend_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      own_q    <= 1'b0;
      gnt_in_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      gnt_in_q <= gnt_in;
      own_q    <= own;
      pend_q   <= pend_q ? ~take : ask;
      if (!pend_q || take) cnt_q <= '0;
      else                 cnt_q <= CW'(retry_step(int'(cnt_q), RETRY_PERIOD));
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take |=> pend_q); // R5
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_q); // R7
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |=> !req_out); // R6
  AST_ASK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    ask && !pend_q |=> req_out); // R2

endmodule

// File: rtl/chain_arbiter.sv
module chain_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_DEV        = 4,
  parameter int unsigned RETRY_PERIOD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_ask,
  input  logic             halt_cmd,
  input  logic             release_cmd,
  output logic             bus_req,
  output logic             grant_root,
  output logic [N_DEV-1:0] dev_own,
  output logic             held
);

  logic [N_DEV:0]   gnt_chain;
  logic [N_DEV-1:0] req_vec;
  logic             chain_tail;

  arb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .halt_cmd    (halt_cmd),
    .release_cmd (release_cmd),
    .grant_root  (grant_root),
    .held        (held)
  );

  assign gnt_chain[0] = grant_root;

  for (genvar i = 0; i < N_DEV; i++) begin : g_cell
    arb_cell #(.RETRY_PERIOD(RETRY_PERIOD)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ask     (dev_ask[i]),
      .gnt_in  (gnt_chain[i]),
      .gnt_out (gnt_chain[i+1]),
      .req_out (req_vec[i]),
      .own     (dev_own[i])
    );
  end

  // Shared wired-OR request line carries no identity.
  assign bus_req    = |req_vec;
  assign chain_tail = gnt_chain[N_DEV];

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_own)); // R9
  AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    grant_root && $past(grant_root) |-> dev_own == $past(dev_own)); // R9
  AST_OWN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_own) |-> grant_root); // R4
  AST_TAIL_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    chain_tail |-> dev_own == '0); // R4

endmodule

// File: tb/chain_arbiter_tb.sv
`timescale 1ns/1ps
module chain_arbiter_tb;
  localparam int N = 4;
  localparam int P = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_ask = '0;
  logic         halt_cmd = 1'b0;
  logic         release_cmd = 1'b0;
  logic         bus_req, grant_root, held;
  logic [N-1:0] dev_own;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  chain_arbiter #(.N_DEV(N), .RETRY_PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_ask(dev_ask), .halt_cmd(halt_cmd),
    .release_cmd(release_cmd), .bus_req(bus_req), .grant_root(grant_root),
    .dev_own(dev_own), .held(held)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected owner in window c for a simultaneous request set m (ascending priority).
  function automatic logic [N-1:0] exp_own(input logic [N-1:0] m, input int c);
    int rank = 0;
    for (int d = 0; d < N; d++) begin
      if (m[d]) begin
        if (c == 1 + P * rank) return N'(1 << d);
        rank++;
      end
    end
    return '0;
  endfunction

  function automatic logic exp_req(input logic [N-1:0] m, input int c);
    return (c % P == 0) && (c / P < $countones(m));
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset own", 32'(dev_own), 0);
    check("R1 reset grant", 32'(grant_root), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset req", 32'(bus_req), 0);
    check("R1 post-reset held", 32'(held), 0);
    check("R1 post-reset own", 32'(dev_own), 0);

    // R2 R3 R4 R6 R7: every set of simultaneous requesters.
    for (int m = 1; m < (1 << N); m++) begin
      dev_ask = N'(m);
      @(negedge clk);
      dev_ask = '0;
      for (int c = 0; c <= 1 + P * N + 2; c++) begin
        if (c > 0) @(negedge clk);
        check($sformatf("R4_R6 own mask=%0h win=%0d", m, c), 32'(dev_own), 32'(exp_own(N'(m), c)));
        check($sformatf("R2_R6 req mask=%0h win=%0d", m, c), 32'(bus_req), 32'(exp_req(N'(m), c)));
        check($sformatf("R3_R7 grant mask=%0h win=%0d", m, c), 32'(grant_root),
              32'(exp_own(N'(m), c) != '0));
      end
      idle(2);
    end

    // R5: a second pulse while pending is ignored.
    dev_ask = 4'b0010;
    @(negedge clk);                       // w0
    check("R5 pending req", 32'(bus_req), 1);
    @(negedge clk);                       // w1
    dev_ask = '0;
    check("R5 owner", 32'(dev_own), 32'h2);
    for (int c = 2; c <= 8; c++) begin
      @(negedge clk);
      check($sformatf("R5 no extra grant win=%0d", c), 32'(dev_own | N'(grant_root)), 0);
    end

    // R8 R9 R10: hold, upstream cell asks during hold, then release.
    dev_ask = 4'b0100;
    @(negedge clk);                       // w0
    dev_ask = '0;
    @(negedge clk);                       // w1
    check("R8 first owner", 32'(dev_own), 32'h4);
    halt_cmd = 1'b1;
    @(negedge clk);                       // w2
    halt_cmd = 1'b0;
    check("R10 held set", 32'(held), 1);
    check("R8 kept owner", 32'(dev_own), 32'h4);
    dev_ask = 4'b0001;
    @(negedge clk);                       // w3
    dev_ask = '0;
    for (int c = 3; c <= 6; c++) begin
      if (c > 3) @(negedge clk);
      check($sformatf("R9 no steal win=%0d", c), 32'(dev_own), 32'h4);
      check($sformatf("R8 grant held win=%0d", c), 32'(grant_root), 1);
    end
    release_cmd = 1'b1;
    @(negedge clk);                       // w7
    release_cmd = 1'b0;
    check("R8 dropped", 32'(grant_root), 0);
    check("R10 held clear", 32'(held), 0);
    @(negedge clk);                       // w8
    check("R6 waiting", 32'(dev_own), 0);
    @(negedge clk);                       // w9
    check("R6 retry req", 32'(bus_req), 1);
    @(negedge clk);                       // w10
    check("R4 upstream served", 32'(dev_own), 32'h1);
    @(negedge clk);                       // w11
    check("R7 one cycle", 32'(dev_own), 0);
    idle(4);

    // R8: halt while idle, release and halt together.
    halt_cmd = 1'b1;
    @(negedge clk);
    halt_cmd = 1'b0;
    check("R10 held from idle", 32'(held), 1);
    dev_ask = 4'b1000;
    @(negedge clk);                       // w0
    dev_ask = '0;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      check($sformatf("R8 idle-halt owner win=%0d", c), 32'(dev_own), 32'h8);
    end
    halt_cmd = 1'b1;
    release_cmd = 1'b1;
    @(negedge clk);
    halt_cmd = 1'b0;
    release_cmd = 1'b0;
    check("R8 release wins", 32'(held), 0);
    check("R8 grant off", 32'(grant_root), 0);
    check("R9 owner off", 32'(dev_own), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule